// File: doc/BRIEF.md
# Carry-increment adder

A parameterized N-bit combinational adder with two operands and a carry-in. It starts like a carry-select adder but does not build two sum candidates per group. Per-bit propagate and generate are formed once for the whole word. The sum XOR is also done once, at the end.

Each group forms prefix generate/propagate terms across its own bits as if its carry-in were zero. When the real carry reaches the group, a single AND-OR per bit corrects each in-group carry. The group's carry-out is formed the same way and passed on to the next group.

Group widths come from a parameter list, least significant group first. The default widths grow toward the top (2,3,4,5,6,6,6 for N=32). This keeps early groups short, so their carries are ready when the chain reaches the wide upper groups.

Top module: `cia_adder`

## Requirements
- R1: For every a_i, b_i and cin_i, the value {cout_o, sum_o} equals the unsigned value a_i + b_i + cin_i.
- R2: The block has no storage: sum_o and cout_o follow a change of the inputs without any clock edge.
- R3: With a_i all ones, b_i zero and cin_i = 1, the carry ripples through every group, so sum_o is zero and cout_o is 1.
- R4: At every group boundary at bit position L, the carry into bit L is correct in two cases. In the first, a carry-in of 1 propagates through ones below L, so the sum is 1<<L. In the second, a carry is generated in bit L-1 by a_i = b_i = 1<<(L-1), so the sum is 1<<L.
- R5: With a_i = b_i = 0, every bit kills its carry: sum_o equals cin_i in bit 0 and zero elsewhere, and cout_o is 0.
- R6: When a_i XOR b_i is all ones and a_i AND b_i is zero, sum_o is all ones with cout_o = 0 for cin_i = 0. For cin_i = 1, sum_o is zero with cout_o = 1.
- R7: The carry entering each group, and the final carry-out, equal the carry of the reference addition at that group's lowest bit. Group widths are taken from a parameter list ordered from the least significant group upward, and they must add up to N.
- R8: A carry generated only in the top bit (a_i = b_i = 1<<(N-1), cin_i = 0) gives sum_o = 0 and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of bit N-1 |

## Verification
The bench targets carries that cross group boundaries: at each boundary it drives both a carry that ripples in from below and a carry generated right under the boundary. A design that used the wrong group's carry-in, or dropped the increment term, would leave bit L clear. Full-propagate and all-kill words come next. A stuck propagate chain would fail the propagate cases, and a generate term leaking into killed bits would fail the kill cases. Pseudo-random operands with both carry-in values then catch a wrong merge order or a wrong group offset, which a few directed patterns could miss.

// File: rtl/cia_pkg.sv
package cia_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // hi spans the more significant bits
  function automatic pg_t pg_merge(pg_t hi, pg_t lo);
    pg_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  function automatic logic pg_apply(pg_t x, logic ci);
    return x.g | (x.p & ci);
  endfunction

endpackage

// File: rtl/cia_pg_bits.sv
module cia_pg_bits
  import cia_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output pg_t  [W-1:0] pg_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pg_o[i].g = a_i[i] & b_i[i];
    assign pg_o[i].p = a_i[i] ^ b_i[i];
  end

endmodule

// File: rtl/cia_group_prefix.sv
module cia_group_prefix
  import cia_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  pg_t [W-1:0] pg_i,
  output pg_t [W-1:0] pref_o
);

  // pref_o[k] spans bits k..0 of the group, carry-in assumed zero
  assign pref_o[0] = pg_i[0];
  for (genvar k = 1; k < W; k++) begin : g_pref
    assign pref_o[k] = pg_merge(pg_i[k], pref_o[k-1]);
  end

endmodule

// File: rtl/cia_incr.sv
module cia_incr
  import cia_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  pg_t  [W-1:0] pref_i,
  input  logic         ci_i,
  output logic [W-1:0] c_o,
  output logic         co_o
);

  assign c_o[0] = ci_i;
  for (genvar k = 1; k < W; k++) begin : g_inc
    assign c_o[k] = pg_apply(pref_i[k-1], ci_i);
  end
  assign co_o = pg_apply(pref_i[W-1], ci_i);

endmodule

// File: rtl/cia_adder.sv
module cia_adder
  import cia_pkg::*;
#(
  parameter int unsigned N       = 32,
  parameter int unsigned NUM_GRP = 7,
  parameter int unsigned GRP_SZ [NUM_GRP] = '{2, 3, 4, 5, 6, 6, 6}
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  function automatic int unsigned grp_lo(int unsigned j);
    int unsigned s = 0;
    for (int unsigned i = 0; i < j; i++) s += GRP_SZ[i];
    return s;
  endfunction

  localparam int unsigned TOTAL = grp_lo(NUM_GRP);

  if (TOTAL != N) begin : g_bad_cfg
    $error("group widths do not add up to N");
  end

  pg_t  [N-1:0]       pg;
  logic [N-1:0]       carry;
  logic [NUM_GRP:0]   grp_ci;

  cia_pg_bits #(.W(N)) i_pg (
    .a_i  (a_i),
    .b_i  (b_i),
    .pg_o (pg)
  );

  assign grp_ci[0] = cin_i;

  for (genvar j = 0; j < NUM_GRP; j++) begin : g_grp
    localparam int unsigned LO = grp_lo(j);
    localparam int unsigned W  = GRP_SZ[j];
    pg_t [W-1:0] pref;

    cia_group_prefix #(.W(W)) i_pref (
      .pg_i   (pg[LO+W-1:LO]),
      .pref_o (pref)
    );

    cia_incr #(.W(W)) i_inc (
      .pref_i (pref),
      .ci_i   (grp_ci[j]),
      .c_o    (carry[LO+W-1:LO]),
      .co_o   (grp_ci[j+1])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_sum
    assign sum_o[i] = pg[i].p ^ carry[i];
  end

  assign cout_o = grp_ci[NUM_GRP];

endmodule

// File: rtl/cia_adder_chk.sv
module cia_adder_chk #(
  parameter int unsigned N       = 32,
  parameter int unsigned NUM_GRP = 7,
  parameter int unsigned GRP_SZ [NUM_GRP] = '{2, 3, 4, 5, 6, 6, 6}
) (
  input logic [N-1:0]     a_i,
  input logic [N-1:0]     b_i,
  input logic             cin_i,
  input logic [N-1:0]     sum_o,
  input logic             cout_o,
  input logic [NUM_GRP:0] grp_ci
);

  function automatic int unsigned lo_of(int unsigned j);
    int unsigned s = 0;
    for (int unsigned i = 0; i < j; i++) s += GRP_SZ[i];
    return s;
  endfunction

  logic [N:0] ref_s;
  always_comb ref_s = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

  always_comb begin
    AST_SUM_MATCH: assert ({cout_o, sum_o} == ref_s) else $error("sum mismatch"); // R1
    AST_KILL_ALL: assert (!((a_i | b_i) == '0) ||
                          ((sum_o == {{(N-1){1'b0}}, cin_i}) && !cout_o))
      else $error("kill word wrong"); // R5
    AST_FULL_PROP: assert (!(((a_i ^ b_i) == '1) && ((a_i & b_i) == '0)) ||
                           ((sum_o == {N{~cin_i}}) && (cout_o == cin_i)))
      else $error("propagate word wrong"); // R6
    AST_COUT_CHAIN: assert (grp_ci[NUM_GRP] == ref_s[N]) else $error("last carry wrong"); // R7
  end

  for (genvar j = 0; j < NUM_GRP; j++) begin : g_grp_chk
    localparam int unsigned LO = lo_of(j);
    always_comb begin
      AST_GRP_CARRY: assert (grp_ci[j] == (ref_s[LO] ^ a_i[LO] ^ b_i[LO]))
        else $error("group carry wrong"); // R7
    end
  end

endmodule

bind cia_adder cia_adder_chk #(.N(N), .NUM_GRP(NUM_GRP), .GRP_SZ(GRP_SZ)) i_cia_adder_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .grp_ci (grp_ci)
);

// File: tb/test_cia_adder.sv
module test_cia_adder;

  localparam int unsigned N       = 32;
  localparam int unsigned NUM_GRP = 7;
  localparam int unsigned SZ [NUM_GRP] = '{2, 3, 4, 5, 6, 6, 6};
  localparam int unsigned NVEC    = 13;

  // {a, b, cin, expected {cout,sum}}
  localparam logic [97:0] VEC [NVEC] = '{
    {32'h00000000, 32'h00000000, 1'b0, 33'h000000000},
    {32'h00000000, 32'h00000000, 1'b1, 33'h000000001},
    {32'hFFFFFFFF, 32'h00000000, 1'b1, 33'h100000000},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 33'h1FFFFFFFF},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 33'h1FFFFFFFE},
    {32'h00000003, 32'h00000001, 1'b0, 33'h000000004},
    {32'h80000000, 32'h80000000, 1'b0, 33'h100000000},
    {32'h12345678, 32'h87654321, 1'b0, 33'h099999999},
    {32'hAAAAAAAA, 32'h55555555, 1'b1, 33'h100000000},
    {32'hAAAAAAAA, 32'h55555555, 1'b0, 33'h0FFFFFFFF},
    {32'h0000001F, 32'h00000001, 1'b0, 33'h000000020},
    {32'h7FFFFFFF, 32'h00000001, 1'b0, 33'h080000000},
    {32'hDEADBEEF, 32'h01234567, 1'b1, 33'h0DFD10457}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] a, b, sum;
  logic cin, cout;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cia_adder #(.N(N), .NUM_GRP(NUM_GRP), .GRP_SZ(SZ)) i_cia_adder (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
    end
  endtask

  task automatic apply(input logic [N-1:0] ta, input logic [N-1:0] tb, input logic tc);
    @(posedge clk);
    a = ta; b = tb; cin = tc;
    @(negedge clk);
  endtask

  function automatic logic [N:0] ref_add(logic [N-1:0] x, logic [N-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
  endfunction

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R1, R3, R5, R6, R8 table walk
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][97:66], VEC[v][65:34], VEC[v][33]);
      check("R1 table", {cout, sum}, VEC[v][32:0]);
    end

    // R5 kill word, both carry-ins
    apply('0, '0, 1'b1);
    check("R5 kill cin=1", {cout, sum}, 33'h000000001);
    // R3 ripple through every group
    apply('1, '0, 1'b1);
    check("R3 full ripple", {cout, sum}, 33'h100000000);
    // R6 propagate word
    apply(32'h0F0F0F0F, 32'hF0F0F0F0, 1'b0);
    check("R6 prop cin=0", {cout, sum}, 33'h0FFFFFFFF);
    apply(32'h0F0F0F0F, 32'hF0F0F0F0, 1'b1);
    check("R6 prop cin=1", {cout, sum}, 33'h100000000);
    // R8 top-bit generate
    apply(32'h80000000, 32'h80000000, 1'b0);
    check("R8 top generate", {cout, sum}, 33'h100000000);

    // R4 / R7 each group boundary
    begin
      int unsigned lo = 0;
      for (int j = 0; j < NUM_GRP - 1; j++) begin
        lo += SZ[j];
        apply((32'h1 << lo) - 32'h1, '0, 1'b1);
        check("R4 R7 boundary ripple", {cout, sum}, 33'h1 << lo);
        apply(32'h1 << (lo - 1), 32'h1 << (lo - 1), 1'b0);
        check("R4 R7 boundary generate", {cout, sum}, 33'h1 << lo);
      end
    end

    // R2 no clock edge needed: change inputs mid-cycle and sample before next edge
    @(posedge clk);
    #2;
    a = 32'h00000100; b = 32'h00000F00; cin = 1'b1;
    #1;
    check("R2 combinational", {cout, sum}, 33'h000001001);

    // R1 pseudo-random sweep
    begin
      logic [31:0] s = 32'h1234ABCD;
      for (int k = 0; k < 2000; k++) begin
        logic [N-1:0] ra, rb;
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        ra = s;
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        rb = s;
        apply(ra, rb, s[7]);
        check("R1 random", {cout, sum}, ref_add(ra, rb, s[7]));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule